// File: doc/BRIEF.md
# Quadrature Pulse Counter with Glitch Filter

This block counts events on two pad inputs, a primary line S0 and a secondary line S1, and keeps a count that wraps inside the range 0 to an active top value. Both pads pass through a synchronizer on the block clock. Three modes pick how S0 and S1 turn into count events. The sampled mode counts each rising edge of S0 and can put S0 through a pulse-width filter. The edge mode takes the raw S0 rising edges and uses the S1 level to choose the direction. The quadrature mode captures S1 at both edges of S0 and decides from the two captured bits whether to count and in which direction.

Software reaches the block through a small register port. It has a control word with the mode, the filter switch and a domain hold bit. It also has a writable next-top buffer, write-one-to-clear wrap flags, and read-only views of the count, the active top and the last direction. While the hold bit is set, the counting logic is forced into reset at once. Clearing the bit lets it run again two clock edges later. The active top is never written directly. It takes the buffered value on the first clock after the domain leaves reset and again on every wrap.

Top module: `pulse_quad_counter`

## Requirements
- R1: After rst_n the control word reads 0x08 (hold bit 3 set, mode bits [1:0] = 0, filter bit 2 = 0), the count reads 0, the active top reads TOP_RST (0xFF by default) and both flags read 0.
- R2: While control bit 3 is 1, the count stays 0 and the active top stays TOP_RST, whatever S0 and S1 do. Setting the bit mid-run drops the count to 0 at once.
- R3: After control bit 3 is cleared, the counting logic stays in reset for two more clock edges and then counts normally.
- R4: In the sampled mode (mode 0), each rising edge of the S0 level counts up by one.
- R5: In mode 0 with the filter bit set, a new S0 level is accepted only after it has been sampled on 5 consecutive clocks. A high pulse of 4 clocks is not counted and one of 5 clocks is.
- R6: With the filter bit clear, or in any other mode, S0 pulses as short as 2 clocks are counted.
- R7: In edge mode (mode 1), an S0 rising edge counts up if S1 is 0 and down if S1 is 1. The direction status (address 5, bit 0) shows 0 for up and 1 for down.
- R8: In quadrature mode (mode 2), S1 is captured at each S0 rising edge and each S0 falling edge. A rising capture of 0 and a falling capture of 1 counts up once at the falling edge and sets the direction status to 0.
- R9: In quadrature mode, a rising capture of 1 and a falling capture of 0 counts down once and sets the direction status to 1.
- R10: In quadrature mode, equal rising and falling captures leave the count unchanged.
- R11: Counting up from the active top gives 0, sets the overflow flag (address 2, bit 0) and loads the next-top buffer into the active top.
- R12: Counting down from 0 loads the next-top buffer into both the count and the active top, and sets the underflow flag (address 2, bit 1).
- R13: The active top (address 4) is read-only and changes only by taking the next-top buffer (address 1), either on the first clock after reset release or at a wrap. The count never exceeds the active top.
- R14: Writing 1 to a flag bit at address 2 clears that flag and leaves the other. If a wrap sets a flag in the same cycle that a write clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples pads and runs the count |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 next top, 2 flag clear |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address: 0 control, 1 next top, 2 flags, 3 count, 4 active top, 5 direction |
| rd_data | output | CNT_W | Combinational read data, zero-extended |
| s0_in | input | 1 | Primary pad input |
| s1_in | input | 1 | Secondary pad input |
| wrap_flag | output | 1 | OR of the overflow and underflow flags |

## Verification
A wrap can set a flag in the same cycle that a software write clears that same flag. The bench brings the count to the active top and then raises S0. It places the clear write so that it lands on exactly the clock where the synchronized edge makes the count wrap. That clock is the third edge after S0 is driven. The overflow flag must then read 1 and the count 0. A later clear with no wrap must bring the flag to 0.

// File: rtl/pqc_pkg.sv
package pqc_pkg;
   typedef enum logic [1:0] {
      MODE_SAMPLED = 2'd0,
      MODE_EDGE    = 2'd1,
      MODE_QUAD    = 2'd2,
      MODE_IDLE    = 2'd3
   } pqc_mode_e;

   localparam logic [2:0] ADR_CTRL  = 3'd0;
   localparam logic [2:0] ADR_NTOP  = 3'd1;
   localparam logic [2:0] ADR_FLAGS = 3'd2;
   localparam logic [2:0] ADR_COUNT = 3'd3;
   localparam logic [2:0] ADR_TOP   = 3'd4;
   localparam logic [2:0] ADR_DIR   = 3'd5;

   localparam int CTRL_BITS = 4;
   localparam int BIT_FILT  = 2;
   localparam int BIT_HOLD  = 3;
endpackage

// File: rtl/pqc_sync.sv
module pqc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] st;

   generate
      if (STAGES < 1) begin : g_bad
         $error("pqc_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or posedge arst)
            if (arst) st <= '0;
            else      st <= d;
      end else begin : g_chain
         always_ff @(posedge clk or posedge arst)
            if (arst) st <= '0;
            else      st <= {st[STAGES-2:0], d};
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/pqc_glitch.sv
module pqc_glitch #(
   parameter int LEN = 5
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   localparam int RW = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [RW-1:0] RUN_LAST = RW'(LEN - 1);

   logic          lvl;
   logic [RW-1:0] run;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         lvl <= 1'b0;
         run <= '0;
      end else if (d == lvl) begin
         run <= '0;
      end else if (run == RUN_LAST) begin
         lvl <= d;
         run <= '0;
      end else begin
         run <= run + 1'b1;
      end
   end

   assign q = lvl;
endmodule

// File: rtl/pqc_decode.sv
module pqc_decode
   import pqc_pkg::*;
(
   input  logic      clk,
   input  logic      arst,
   input  logic      lvl,
   input  logic      s1,
   input  pqc_mode_e mode,
   output logic      up_ev,
   output logic      dn_ev
);
   logic prev_lvl;
   logic rise_cap;
   logic rise, fall;

   assign rise = lvl & ~prev_lvl;
   assign fall = ~lvl & prev_lvl;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         prev_lvl <= 1'b0;
         rise_cap <= 1'b0;
      end else begin
         prev_lvl <= lvl;
         if (rise) rise_cap <= s1;
      end
   end

   always_comb begin
      up_ev = 1'b0;
      dn_ev = 1'b0;
      unique case (mode)
         MODE_SAMPLED: up_ev = rise;
         MODE_EDGE: begin
            up_ev = rise & ~s1;
            dn_ev = rise & s1;
         end
         MODE_QUAD: begin
            up_ev = fall & ~rise_cap & s1;
            dn_ev = fall & rise_cap & ~s1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pqc_count.sv
module pqc_count #(
   parameter int               W       = 8,
   parameter logic [W-1:0]     TOP_RST = '1
) (
   input  logic         clk,
   input  logic         arst,
   input  logic         up_ev,
   input  logic         dn_ev,
   input  logic [W-1:0] next_top,
   input  logic         clr_ovf,
   input  logic         clr_unf,
   output logic [W-1:0] cnt,
   output logic [W-1:0] top,
   output logic         ovf,
   output logic         unf,
   output logic         dir
);
   logic primed;
   logic set_ovf, set_unf;

   assign set_ovf = primed & up_ev & (cnt == top);
   assign set_unf = primed & dn_ev & (cnt == '0);

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         primed <= 1'b0;
         cnt    <= '0;
         top    <= TOP_RST;
         dir    <= 1'b0;
      end else if (!primed) begin
         primed <= 1'b1;
         top    <= next_top;
      end else if (up_ev) begin
         dir <= 1'b0;
         if (set_ovf) begin
            cnt <= '0;
            top <= next_top;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else if (dn_ev) begin
         dir <= 1'b1;
         if (set_unf) begin
            cnt <= next_top;
            top <= next_top;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         ovf <= 1'b0;
         unf <= 1'b0;
      end else begin
         ovf <= (ovf & ~clr_ovf) | set_ovf;
         unf <= (unf & ~clr_unf) | set_unf;
      end
   end
endmodule

// File: rtl/pulse_quad_counter.sv
module pulse_quad_counter
   import pqc_pkg::*;
#(
   parameter int               CNT_W      = 8,
   parameter logic [CNT_W-1:0] TOP_RST    = '1,
   parameter int               SYNC_N     = 2,
   parameter int               FILT_LEN   = 5,
   parameter bit               HAS_FILTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [2:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             s0_in,
   input  logic             s1_in,
   output logic             wrap_flag
);
   generate
      if (CNT_W < CTRL_BITS) begin : g_chk_w
         $error("pulse_quad_counter: CNT_W too small for the control word");
      end
      if (FILT_LEN < 2) begin : g_chk_f
         $error("pulse_quad_counter: FILT_LEN must be at least 2");
      end
   endgenerate

   // register-port state
   logic [CTRL_BITS-1:0] ctrl_q;
   logic [CNT_W-1:0]     ntop_q;
   pqc_mode_e            mode;
   logic                 filt_on, hold_q;

   assign mode    = pqc_mode_e'(ctrl_q[1:0]);
   assign filt_on = ctrl_q[BIT_FILT];
   assign hold_q  = ctrl_q[BIT_HOLD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_BITS'(1) << BIT_HOLD;
         ntop_q <= TOP_RST;
      end else if (wr_en) begin
         if (wr_addr == ADR_CTRL) ctrl_q <= wr_data[CTRL_BITS-1:0];
         if (wr_addr == ADR_NTOP) ntop_q <= wr_data;
      end
   end

   // domain hold: asynchronous entry, release after two clock edges
   logic       hold_set;
   logic [1:0] rel_q;
   logic       dom_rst;

   assign hold_set = hold_q | ~rst_n;

   always_ff @(posedge clk or posedge hold_set)
      if (hold_set) rel_q <= 2'b11;
      else          rel_q <= {rel_q[0], 1'b0};

   assign dom_rst = rel_q[1];

   // pad path
   logic s0_s, s1_s, s0_f, s0_lvl;

   pqc_sync #(.STAGES(SYNC_N)) u_sync0 (.clk(clk), .arst(dom_rst), .d(s0_in), .q(s0_s));
   pqc_sync #(.STAGES(SYNC_N)) u_sync1 (.clk(clk), .arst(dom_rst), .d(s1_in), .q(s1_s));

   generate
      if (HAS_FILTER) begin : g_filt
         pqc_glitch #(.LEN(FILT_LEN)) u_glitch (
            .clk(clk), .arst(dom_rst), .d(s0_s), .q(s0_f));
      end else begin : g_nofilt
         assign s0_f = s0_s;
      end
   endgenerate

   assign s0_lvl = (mode == MODE_SAMPLED && filt_on) ? s0_f : s0_s;

   // event decode and count
   logic             up_ev, dn_ev;
   logic [CNT_W-1:0] cnt, top;
   logic             ovf, unf, dir;
   logic             clr_ovf, clr_unf;

   assign clr_ovf = wr_en && wr_addr == ADR_FLAGS && wr_data[0];
   assign clr_unf = wr_en && wr_addr == ADR_FLAGS && wr_data[1];

   pqc_decode u_dec (
      .clk(clk), .arst(dom_rst), .lvl(s0_lvl), .s1(s1_s), .mode(mode),
      .up_ev(up_ev), .dn_ev(dn_ev));

   pqc_count #(.W(CNT_W), .TOP_RST(TOP_RST)) u_cnt (
      .clk(clk), .arst(dom_rst), .up_ev(up_ev), .dn_ev(dn_ev),
      .next_top(ntop_q), .clr_ovf(clr_ovf), .clr_unf(clr_unf),
      .cnt(cnt), .top(top), .ovf(ovf), .unf(unf), .dir(dir));

   assign wrap_flag = ovf | unf;

   always_comb begin
      unique case (rd_addr)
         ADR_CTRL:  rd_data = CNT_W'(ctrl_q);
         ADR_NTOP:  rd_data = ntop_q;
         ADR_FLAGS: rd_data = CNT_W'({unf, ovf});
         ADR_COUNT: rd_data = cnt;
         ADR_TOP:   rd_data = top;
         ADR_DIR:   rd_data = CNT_W'(dir);
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/pqc_chk.sv
module pqc_chk #(
   parameter int           W       = 8,
   parameter logic [W-1:0] TOP_RST = '1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         hold_q,
   input logic         dom_rst,
   input logic [W-1:0] cnt,
   input logic [W-1:0] top,
   input logic         ovf,
   input logic         unf
);
   a_r2_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |-> (cnt == '0 && top == TOP_RST));

   a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_q) |=> dom_rst ##1 !dom_rst);

   a_r11_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> cnt == '0);

   a_r12_unf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unf) |-> cnt == top);

   a_r13_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_rst |-> cnt <= top);
endmodule

bind pulse_quad_counter pqc_chk #(.W(CNT_W), .TOP_RST(TOP_RST)) u_chk (
   .clk(clk), .rst_n(rst_n), .hold_q(hold_q), .dom_rst(dom_rst),
   .cnt(cnt), .top(top), .ovf(ovf), .unf(unf));

// File: tb/sim_pulse_quad_counter.sv
module sim_pulse_quad_counter;
   localparam int CLK_P = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [2:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         s0_in = 1'b0;
   logic         s1_in = 1'b0;
   logic         wrap_flag;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench model
   int exp_cnt, exp_top, exp_ntop;
   bit exp_ovf, exp_unf;

   always #(CLK_P/2) clk = ~clk;

   pulse_quad_counter u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .s0_in(s0_in), .s1_in(s1_in), .wrap_flag(wrap_flag));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input int d);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int d);
      rd_addr = a;
      #1;
      d = int'(rd_data);
   endtask

   task automatic m_up();
      if (exp_cnt == exp_top) begin
         exp_cnt = 0; exp_top = exp_ntop; exp_ovf = 1'b1;
      end else exp_cnt++;
   endtask

   task automatic m_dn();
      if (exp_cnt == 0) begin
         exp_cnt = exp_ntop; exp_top = exp_ntop; exp_unf = 1'b1;
      end else exp_cnt--;
   endtask

   task automatic pulse(input int hi, input int lo);
      s0_in = 1'b1; wait_n(hi);
      s0_in = 1'b0; wait_n(lo);
   endtask

   task automatic quad_cycle(input bit fwd);
      if (fwd) begin
         s0_in = 1'b1; wait_n(2); s1_in = 1'b1; wait_n(2);
         s0_in = 1'b0; wait_n(2); s1_in = 1'b0; wait_n(2);
      end else begin
         s1_in = 1'b1; wait_n(2); s0_in = 1'b1; wait_n(2);
         s1_in = 1'b0; wait_n(2); s0_in = 1'b0; wait_n(2);
      end
   endtask

   task automatic check_state(input string tag);
      int v;
      wait_n(4);
      rd(3'd3, v); chk({tag, " count"}, v, exp_cnt);
      rd(3'd4, v); chk({tag, " top"}, v, exp_top);
      rd(3'd2, v); chk({tag, " flags"}, v, {exp_unf, exp_ovf});
   endtask

   task automatic t_reset();
      int v;
      rd(3'd0, v); chk("R1 ctrl", v, 8);
      exp_cnt = 0; exp_top = 255; exp_ntop = 255; exp_ovf = 0; exp_unf = 0;
      check_state("R1 reset");
      chk("R1 wrap_flag", int'(wrap_flag), 0);
      // R2: pulses while held do nothing
      for (int i = 0; i < 3; i++) pulse(3, 3);
      check_state("R2 held");
   endtask

   task automatic t_release();
      wr(3'd1, 9); exp_ntop = 9;
      wr(3'd0, 0);
      wait_n(5); exp_top = 9;
      check_state("R3 R13 release");
      pulse(3, 3); m_up();
      check_state("R3 counts after release");
   endtask

   task automatic t_sampled();
      for (int i = 0; i < 2; i++) begin pulse(2, 2); m_up(); end
      check_state("R4 R6 short pulses");
   endtask

   task automatic t_filter();
      wr(3'd0, 4);
      wait_n(8);
      pulse(4, 8);
      check_state("R5 4-clock glitch");
      pulse(5, 8); m_up();
      check_state("R5 5-clock pulse");
      wr(3'd0, 0);
      wait_n(8);
   endtask

   task automatic t_edge();
      int v;
      wr(3'd0, 1);
      s1_in = 1'b0; wait_n(3);
      pulse(3, 3); m_up();
      pulse(3, 3); m_up();
      rd(3'd5, v); chk("R7 dir up", v, 0);
      s1_in = 1'b1; wait_n(3);
      pulse(3, 3); m_dn();
      s1_in = 1'b0; wait_n(3);
      rd(3'd5, v); chk("R7 dir down", v, 1);
      check_state("R7 edge mode");
   endtask

   task automatic t_quad();
      int v;
      wr(3'd0, 2);
      wait_n(3);
      for (int i = 0; i < 4; i++) begin quad_cycle(1'b1); m_up(); end
      check_state("R8 quad fwd");
      rd(3'd5, v); chk("R8 dir", v, 0);
      for (int i = 0; i < 3; i++) begin quad_cycle(1'b0); m_dn(); end
      check_state("R9 quad rev");
      rd(3'd5, v); chk("R9 dir", v, 1);
      s1_in = 1'b0; pulse(3, 3); pulse(3, 3);
      s1_in = 1'b1; wait_n(3); pulse(3, 3);
      s1_in = 1'b0; wait_n(3);
      check_state("R10 quad equal captures");
   endtask

   task automatic t_wrap();
      wr(3'd0, 0);
      wr(3'd1, 5); exp_ntop = 5;
      wait_n(3);
      while (exp_ovf == 1'b0) begin pulse(3, 3); m_up(); end
      check_state("R11 R13 up wrap");
      wr(3'd0, 1);
      s1_in = 1'b1; wait_n(3);
      pulse(3, 3); m_dn();
      s1_in = 1'b0; wait_n(3);
      check_state("R12 down wrap");
      wr(3'd4, 77);
      check_state("R13 top read-only");
   endtask

   task automatic t_flags();
      wr(3'd2, 2); exp_unf = 1'b0;
      check_state("R14 clear unf only");
      // count is at top: next up event wraps while ovf clear lands
      wr(3'd0, 0);
      wait_n(3);
      s0_in = 1'b1;
      wait_n(2);
      wr(3'd2, 1);
      m_up();
      wait_n(3);
      s0_in = 1'b0;
      check_state("R14 set beats clear");
      wr(3'd2, 1); exp_ovf = 1'b0;
      check_state("R14 clear ovf");
   endtask

   task automatic t_midhold();
      pulse(3, 3); m_up();
      pulse(3, 3); m_up();
      check_state("R2 pre-hold");
      wr(3'd0, 8);
      exp_cnt = 0; exp_top = 255; exp_ovf = 0; exp_unf = 0;
      pulse(3, 3);
      check_state("R2 mid-run hold");
      wr(3'd1, 12); exp_ntop = 12;
      wr(3'd0, 0);
      wait_n(5); exp_top = 12;
      pulse(3, 3); m_up();
      check_state("R3 R13 second release");
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      t_reset();
      t_release();
      t_sampled();
      t_filter();
      t_edge();
      t_quad();
      t_wrap();
      t_flags();
      t_midhold();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule